// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

The block collects the single-cycle event pulses of a bus-monitor function and presents them to a host. Each source has two mask bits. An enable mask drops an event completely when its bit is clear. For an event that is kept, an output-enable mask decides whether it drives the shared active-low interrupt line or only waits in the pending register until the host polls it. A kept event also writes its bit into a small circular log, so the host can see the order in which events arrived.

The host reaches the block through a simple synchronous request port with word addresses. Read data is registered and appears in the cycle after the request. Reading the pending register returns its contents and clears it in the same access. Reading the log address removes the oldest entry. A summary bit in a wider hardware pending vector shows whether any pending bit is set.

Top module: `mon_irq_ctrl`

## Requirements
- R1: After reset the enable, pending and output-enable registers read 0, `irq_no` is 1, `hw_pend_o` is 0 and the log is empty.
- R2: An event on a source whose enable bit is 0 has no effect at the ports. It sets no pending bit, adds no log entry and does not pull `irq_no` low.
- R3: An event on an enabled source sets its pending bit at the next clock edge and pushes one log entry that holds the vector of accepted bits.
- R4: Setting an enable bit from 0 to 1 flags nothing for events that arrived while the bit was 0.
- R5: Bit 1 of `hw_pend_o` is 1 exactly when some pending bit is set. All other bits of `hw_pend_o` are 0.
- R6: `irq_no` is 0 exactly when some pending bit has its output-enable bit set. It goes low at the same edge that sets the pending bit. A source whose output-enable bit is clear never pulls it low.
- R7: A read of the pending register returns its value and clears it. An event accepted in the same cycle as that read stays set.
- R8: The log holds 16 entries and returns them oldest first, one per read of address 0x18. When the log is full, a new entry replaces the oldest one. A read of an empty log returns 0.
- R9: Several events accepted in one cycle produce one pending update and exactly one log entry.
- R10: Address map: enable at 0x11 and output-enable at 0x15, both read/write. Pending is at 0x08 and is read-only, so writes to it are ignored. The log is at 0x18. Reads of unmapped addresses return 0. Read data is valid in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses, one bit per source |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Host word address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Registered host read data |
| irq_no | output | 1 | Interrupt line, active low |
| hw_pend_o | output | 16 | Hardware pending vector, summary in bit 1 |

## Verification
The bench builds the block with its defaults: 16 sources and a 16-entry log. This is small enough to sweep every source one at a time, with odd sources set to high priority and even sources to low priority, while all 16 event lines pulse together. Each sweep step checks the pending value, the log entry and the interrupt line for that source alone. With a 16-entry log, filling it past capacity takes 18 events, which is enough to confirm that the two oldest entries are dropped. Directed cases then cover a clearing read in the same cycle as a new event, late enabling, merged events, and writes to the read-only register.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned HW_W    = 16;
  localparam int unsigned SUM_BIT = 1;
  localparam logic [ADDR_W-1:0] A_PEND = 8'h08;
  localparam logic [ADDR_W-1:0] A_EN   = 8'h11;
  localparam logic [ADDR_W-1:0] A_OE   = 8'h15;
  localparam logic [ADDR_W-1:0] A_LOG  = 8'h18;
endpackage

// File: rtl/mon_irq_core.sv
module mon_irq_core #(
  parameter int unsigned SRC_N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] evt_i,
  input  logic             en_we_i,
  input  logic             oe_we_i,
  input  logic [SRC_N-1:0] wdata_i,
  input  logic             pend_clr_i,
  output logic [SRC_N-1:0] en_o,
  output logic [SRC_N-1:0] oe_o,
  output logic [SRC_N-1:0] pend_o,
  output logic [SRC_N-1:0] accept_o,
  output logic             hi_pend_o
);
  logic [SRC_N-1:0] en_q, oe_q, pend_q, accept;

  // events on disabled sources are dropped here, never stored
  assign accept = evt_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      oe_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      if (oe_we_i) oe_q <= wdata_i;
      pend_q <= (pend_clr_i ? '0 : pend_q) | accept;
    end
  end

  assign en_o      = en_q;
  assign oe_o      = oe_q;
  assign pend_o    = pend_q;
  assign accept_o  = accept;
  assign hi_pend_o = |(pend_q & oe_q);

  p_only_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_q & ~$past(pend_q) & ~$past(en_q))));

  p_accept_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|accept) |=> ((pend_q & $past(accept)) == $past(accept)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_clr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_clr_i |=> (pend_q == $past(accept)));
endmodule

// File: rtl/mon_irq_log.sv
module mon_irq_log #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count_q == CNT_MAX);
  assign empty  = (count_q == '0);
  assign pop_ok = pop_i && !empty;
  assign pop_data_o = empty ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      // overwrite when full drops the oldest entry
      if (pop_ok || (push_i && full)) rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_i, pop_ok})
        2'b10:   if (!full) count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_MAX);

  p_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (count_q == $past(count_q)));

  p_push_grows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
  import mon_irq_pkg::*;
#(
  parameter int unsigned SRC_N     = 16,
  parameter int unsigned LOG_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_N-1:0]  wdata_i,
  output logic [SRC_N-1:0]  rdata_o,
  output logic              irq_no,
  output logic [HW_W-1:0]   hw_pend_o
);
  logic             wr, rd;
  logic [SRC_N-1:0] en, oe, pend, accept, log_data, rd_next, rdata_q;
  logic             hi_pend;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  mon_irq_core #(.SRC_N(SRC_N)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .en_we_i    (wr && (addr_i == A_EN)),
    .oe_we_i    (wr && (addr_i == A_OE)),
    .wdata_i    (wdata_i),
    .pend_clr_i (rd && (addr_i == A_PEND)),
    .en_o       (en),
    .oe_o       (oe),
    .pend_o     (pend),
    .accept_o   (accept),
    .hi_pend_o  (hi_pend)
  );

  mon_irq_log #(.W(SRC_N), .DEPTH(LOG_DEPTH)) u_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (|accept),
    .push_data_i (accept),
    .pop_i       (rd && (addr_i == A_LOG)),
    .pop_data_o  (log_data)
  );

  always_comb begin
    unique case (addr_i)
      A_EN:    rd_next = en;
      A_OE:    rd_next = oe;
      A_PEND:  rd_next = pend;
      A_LOG:   rd_next = log_data;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
  assign irq_no  = ~hi_pend;

  for (genvar b = 0; b < HW_W; b++) begin : g_hw
    if (b == SUM_BIT) begin : g_sum
      assign hw_pend_o[b] = |pend;
    end else begin : g_zero
      assign hw_pend_o[b] = 1'b0;
    end
  end

  p_irq_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(accept & oe)) |=> !irq_no);
endmodule

// File: tb/mon_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mon_irq_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] evt = '0, wdata = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] rdata, hw_pend;
  logic        irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mon_irq_ctrl u_mon_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n),
    .hw_pend_o(hw_pend)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic [15:0] e = '0);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a; evt = e;
    @(negedge clk); req = 1'b0; evt = '0; d = rdata;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_no", {15'd0, irq_n}, 16'd1);
    chk("R1 hw_pend", hw_pend, 16'd0);
    rd(8'h11, d); chk("R1 en", d, 0);
    rd(8'h08, d); chk("R1 pend", d, 0);
    rd(8'h15, d); chk("R1 oe", d, 0);
    rd(8'h18, d); chk("R1 log empty", d, 0);

    // sweep one enabled source, odd sources high priority (R2 R3 R5 R6 R9)
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'(1) << i;
      wr(8'h11, b);
      wr(8'h15, (i % 2 == 1) ? b : 16'h0);
      pulse(16'hFFFF);
      chk("R5 summary set", hw_pend, 16'h0002);
      chk("R6 irq by priority", {15'd0, irq_n}, (i % 2 == 1) ? 16'd0 : 16'd1);
      rd(8'h08, d); chk("R3 pend one bit", d, b);
      chk("R6 irq released", {15'd0, irq_n}, 16'd1);
      chk("R5 summary clear", hw_pend, 16'd0);
      rd(8'h08, d); chk("R7 pend cleared", d, 0);
      rd(8'h18, d); chk("R3 log entry", d, b);
      rd(8'h18, d); chk("R9 one entry R2", d, 0);
    end

    // R2 everything disabled
    wr(8'h11, 16'h0); wr(8'h15, 16'hFFFF);
    pulse(16'hFFFF);
    chk("R2 irq", {15'd0, irq_n}, 16'd1);
    chk("R2 summary", hw_pend, 16'd0);
    rd(8'h08, d); chk("R2 pend", d, 0);
    rd(8'h18, d); chk("R2 log", d, 0);

    // R4 late enable
    pulse(16'h00F0);
    wr(8'h11, 16'h00F0);
    rd(8'h08, d); chk("R4 pend", d, 0);
    rd(8'h18, d); chk("R4 log", d, 0);
    chk("R4 irq", {15'd0, irq_n}, 16'd1);

    // R9 merged events, low priority
    wr(8'h11, 16'hFFFF); wr(8'h15, 16'h0);
    pulse(16'hA5A5);
    chk("R6 low prio no irq", {15'd0, irq_n}, 16'd1);
    rd(8'h08, d); chk("R9 pend merged", d, 16'hA5A5);
    rd(8'h18, d); chk("R9 log merged", d, 16'hA5A5);
    rd(8'h18, d); chk("R9 single entry", d, 0);

    // R7 event during clearing read
    pulse(16'h0001);
    rd(8'h08, d, 16'h0100); chk("R7 read value", d, 16'h0001);
    rd(8'h08, d); chk("R7 event kept", d, 16'h0100);
    rd(8'h18, d); chk("R7 log first", d, 16'h0001);
    rd(8'h18, d); chk("R7 log second", d, 16'h0100);

    // R10 map
    wr(8'h08, 16'hFFFF);
    rd(8'h08, d); chk("R10 pend ro", d, 0);
    wr(8'h11, 16'h1234); rd(8'h11, d); chk("R10 en rw", d, 16'h1234);
    wr(8'h15, 16'hABCD); rd(8'h15, d); chk("R10 oe rw", d, 16'hABCD);
    rd(8'h02, d); chk("R10 unmapped", d, 0);

    // R8 overwrite oldest
    wr(8'h11, 16'hFFFF); wr(8'h15, 16'h0);
    for (int k = 1; k <= 18; k++) pulse(16'(k));
    rd(8'h08, d);
    for (int k = 3; k <= 18; k++) begin
      rd(8'h18, d); chk("R8 log order", d, 16'(k));
    end
    rd(8'h18, d); chk("R8 drained", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule